// File: doc/BRIEF.md
# Operand-Size Aware Register Writeback

This block is the writeback end of a sixteen-entry, 64-bit general-purpose register file. Each incoming result carries a 2-bit operand-size code. From that code the block decides how the result combines with the destination's current contents. Full-width results replace the register. Word results (32 bits) are zero-extended. Byte and halfword results overwrite only their low lane and keep every higher bit of the register.

The block also produces a one-hot flag vector that marks the destination register whenever the write has to read its old contents. Only byte and halfword writes do this. A rename or scoreboard stage can use the flag to decide whether a producer must wait for the prior value. Two combinational read ports return register contents. When a read port names the register being written in the same cycle, it forwards the merged value.

Top module: `gpr_size_wb`

## Requirements
- R1: With size code 2'b11 (64-bit), a valid write stores all 64 bits of the result in the destination register.
- R2: With size code 2'b10 (32-bit), a valid write stores result bits 31:0 in bits 31:0 and writes zero to bits 63:32 of the destination.
- R3: With size code 2'b00 (8-bit), a valid write replaces only bits 7:0 and leaves bits 63:8 of the destination unchanged.
- R4: With size code 2'b01 (16-bit), a valid write replaces only bits 15:0 and leaves bits 63:16 of the destination unchanged.
- R5: `old_needed[i]` is high exactly when the write is valid, the destination index is i, and the size code is 2'b00 or 2'b01. All other bits are zero, and the whole vector is zero for 32-bit and 64-bit writes or when no write is valid.
- R6: The register array changes only on a rising clock edge with `wr_valid` high. When `wr_valid` is low, the data, index and size inputs have no effect on any register.
- R7: A read port whose index equals the destination of a valid write in the same cycle returns the merged value that the write will store.
- R8: Synchronous active-high reset clears all sixteen registers to zero.
- R9: The two read ports are independent. Each returns the register named by its own index, or the forwarded value under R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request qualifier |
| wr_idx | input | 4 | Destination register index |
| wr_size | input | 2 | Operand size: 00=8, 01=16, 10=32, 11=64 bits |
| wr_data | input | 64 | Result value; only the low lane of the given size is used |
| rd_idx_a | input | 4 | Read port A index |
| rd_data_a | output | 64 | Read port A data (with forwarding) |
| rd_idx_b | input | 4 | Read port B index |
| rd_data_b | output | 64 | Read port B data (with forwarding) |
| old_needed | output | 16 | One-hot flag: this cycle's write depends on the destination's old value |

## Verification
The properties assume that `wr_size`, `wr_idx` and `wr_valid` are known, two-state values at every clock edge. They also assume that reset is held for at least one edge before any write. The merge checks compare the written value with the old contents read in the same cycle, so they depend on the write index being stable across the whole cycle.

The bench drives every input at the falling edge and never leaves an input undriven. It raises reset before the first write. It chooses only indices below sixteen, so every generated index hits a real register.

// File: rtl/gpr_wb_pkg.sv
package gpr_wb_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        OPSZ_B = 2'b00,
        OPSZ_H = 2'b01,
        OPSZ_W = 2'b10,
        OPSZ_D = 2'b11
    } opsize_e;

    typedef struct packed {
        opsize_e          size;
        logic [XLEN-1:0]  value;
    } wb_result_t;

    function automatic logic [XLEN-1:0] lane_mask(opsize_e s);
        logic [XLEN-1:0] m;
        case (s)
            OPSZ_B:  m = {{(XLEN-8){1'b0}},  {8{1'b1}}};
            OPSZ_H:  m = {{(XLEN-16){1'b0}}, {16{1'b1}}};
            OPSZ_W:  m = {{(XLEN-32){1'b0}}, {32{1'b1}}};
            default: m = {XLEN{1'b1}};
        endcase
        return m;
    endfunction

    function automatic logic keeps_upper(opsize_e s);
        return (s == OPSZ_B) || (s == OPSZ_H);
    endfunction

endpackage

// File: rtl/gpr_wb_merge.sv
module gpr_wb_merge
    import gpr_wb_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  wb_result_t      res,
    output logic [XLEN-1:0] new_val,
    output logic            uses_old
);
    logic [XLEN-1:0] lmask;

    always_comb begin
        lmask    = lane_mask(res.size);
        uses_old = keeps_upper(res.size);
        new_val  = res.value & lmask;
        if (uses_old) begin
            new_val = new_val | (old_val & ~lmask);
        end
    end
endmodule

// File: rtl/gpr_wb_regarray.sv
module gpr_wb_regarray
    import gpr_wb_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NRD   = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [XLEN-1:0]  wval,
    output logic [XLEN-1:0]  wold,
    input  logic [IDX_W-1:0] ridx [NRD],
    output logic [XLEN-1:0]  rraw [NRD]
);
    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wval;
        end
    end

    assign wold = mem[widx];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rraw[p] = mem[ridx[p]];
    end

    // R6: a valid write lands in the addressed entry at the edge
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wval));

    // R6: with no write, the entry under the write index keeps its value
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !we |=> mem[$past(widx)] == $past(wold));

    // R8: reset clears the array
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (mem[0] == '0) && (mem[NREG-1] == '0));
endmodule

// File: rtl/gpr_wb_rdport.sv
module gpr_wb_rdport
    import gpr_wb_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ridx,
    input  logic [XLEN-1:0]  raw,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_val,
    output logic [XLEN-1:0]  rdata
);
    logic hit;

    always_comb begin
        hit   = wr_valid && (wr_idx == ridx);
        rdata = hit ? wr_val : raw;
    end

    // R7: same-cycle read of the write target sees the merged value
    assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_idx == ridx) |-> rdata == wr_val);

    // R9: a port not hit by the write returns the stored entry
    assert_no_hit_raw_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && wr_idx == ridx) |-> rdata == raw);
endmodule

// File: rtl/gpr_wb_depmask.sv
module gpr_wb_depmask
    import gpr_wb_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             partial,
    output logic [NREG-1:0]  dep
);
    for (genvar i = 0; i < NREG; i++) begin : g_dep
        assign dep[i] = wr_valid && partial && (wr_idx == IDX_W'(i));
    end
endmodule

// File: rtl/gpr_size_wb.sv
module gpr_size_wb
    import gpr_wb_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int NRD   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [XLEN-1:0]  rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]  rd_data_b,
    output logic [NREG-1:0]  old_needed
);
    wb_result_t      res;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] wb_val;
    logic            partial;
    logic [IDX_W-1:0] ridx [NRD];
    logic [XLEN-1:0]  rraw [NRD];
    logic [XLEN-1:0]  rout [NRD];

    assign res.size  = opsize_e'(wr_size);
    assign res.value = wr_data;
    assign ridx[0]   = rd_idx_a;
    assign ridx[1]   = rd_idx_b;
    assign rd_data_a = rout[0];
    assign rd_data_b = rout[1];

    gpr_wb_merge u_merge (
        .old_val  (old_val),
        .res      (res),
        .new_val  (wb_val),
        .uses_old (partial)
    );

    gpr_wb_regarray #(.NREG(NREG), .NRD(NRD)) u_array (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_valid),
        .widx (wr_idx),
        .wval (wb_val),
        .wold (old_val),
        .ridx (ridx),
        .rraw (rraw)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        gpr_wb_rdport #(.NREG(NREG)) u_port (
            .clk      (clk),
            .rst      (rst),
            .ridx     (ridx[p]),
            .raw      (rraw[p]),
            .wr_valid (wr_valid),
            .wr_idx   (wr_idx),
            .wr_val   (wb_val),
            .rdata    (rout[p])
        );
    end

    gpr_wb_depmask #(.NREG(NREG)) u_dep (
        .wr_valid (wr_valid),
        .wr_idx   (wr_idx),
        .partial  (partial),
        .dep      (old_needed)
    );

    assert_full_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_size == 2'b11) |-> wb_val == wr_data);

    assert_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_size == 2'b10) |->
            (wb_val[63:32] == 32'h0) && (wb_val[31:0] == wr_data[31:0]));

    assert_byte_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_size == 2'b00) |->
            (wb_val[63:8] == old_val[63:8]) && (wb_val[7:0] == wr_data[7:0]));

    assert_half_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_size == 2'b01) |->
            (wb_val[63:16] == old_val[63:16]) && (wb_val[15:0] == wr_data[15:0]));

    assert_dep_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(old_needed));

    assert_dep_full_free_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid || wr_size[1]) |-> old_needed == '0);
endmodule

// File: tb/gpr_size_wb_bench.sv
module gpr_size_wb_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [3:0]  wr_idx;
    logic [1:0]  wr_size;
    logic [63:0] wr_data;
    logic [3:0]  rd_idx_a, rd_idx_b;
    logic [63:0] rd_data_a, rd_data_b;
    logic [15:0] old_needed;

    int total = 0;
    int bad   = 0;
    logic [63:0] model [16];
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    gpr_size_wb u_gpr_size_wb (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
        .wr_size(wr_size), .wr_data(wr_data), .rd_idx_a(rd_idx_a),
        .rd_data_a(rd_data_a), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .old_needed(old_needed)
    );

    // {size, idx, data, expected dependency flag}
    localparam logic [70:0] VEC [8] = '{
        {2'b11, 4'd3, 64'h1122_3344_5566_7788, 1'b0},
        {2'b00, 4'd3, 64'hFFFF_FFFF_FFFF_FFAA, 1'b1},
        {2'b01, 4'd3, 64'hEEEE_EEEE_EEEE_BBCC, 1'b1},
        {2'b10, 4'd3, 64'hDDDD_DDDD_0BAD_F00D, 1'b0},
        {2'b11, 4'd15, 64'hFEDC_BA98_7654_3210, 1'b0},
        {2'b01, 4'd15, 64'h0000_0000_0000_0000, 1'b1},
        {2'b00, 4'd0, 64'h0000_0000_0000_005A, 1'b1},
        {2'b10, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
    };

    function automatic logic [63:0] expect_val(logic [63:0] old, logic [1:0] sz, logic [63:0] d);
        case (sz)
            2'b00:   return {old[63:8], d[7:0]};
            2'b01:   return {old[63:16], d[15:0]};
            2'b10:   return {32'h0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic string size_req(logic [1:0] sz);
        case (sz)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    // One cycle: drive write and reads at negedge, check combinational outputs, commit at posedge
    task automatic step(logic v, logic [3:0] idx, logic [1:0] sz, logic [63:0] d,
                        logic [3:0] rb, logic exp_dep_in, logic use_exp_dep);
        logic [63:0] merged;
        logic        dep;
        @(negedge clk);
        wr_valid = v; wr_idx = idx; wr_size = sz; wr_data = d;
        rd_idx_a = idx; rd_idx_b = rb;
        #1;
        merged = v ? expect_val(model[idx], sz, d) : model[idx];
        dep    = use_exp_dep ? exp_dep_in : (v && !sz[1]);
        // R7 forwarding on port A (or plain read when idle, R6)
        check(v ? "R7" : "R6", rd_data_a, merged);
        check("R9", rd_data_b, (rb == idx) ? merged : model[rb]);
        check("R5", {48'h0, old_needed}, dep ? (64'h1 << idx) : 64'h0);
        if (v) check(size_req(sz), rd_data_a, expect_val(model[idx], sz, d));
        @(posedge clk);
        if (v) model[idx] = merged;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst = 1'b1; wr_valid = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
        rd_idx_a = '0; rd_idx_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: every register reads zero after reset
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx_a = 4'(i); rd_idx_b = 4'(15 - i);
            #1;
            check("R8", rd_data_a, 64'h0);
            check("R8", rd_data_b, 64'h0);
        end

        // Vector table
        for (int k = 0; k < 8; k++) begin
            step(1'b1, VEC[k][68:65], VEC[k][70:69], VEC[k][64:1],
                 4'(k + 5), VEC[k][0], 1'b1);
        end

        // R6: idle cycle with live-looking data touches nothing
        step(1'b0, 4'd3, 2'b11, 64'hDEAD_BEEF_DEAD_BEEF, 4'd3, 1'b0, 1'b1);
        @(negedge clk);
        wr_valid = 1'b0; rd_idx_a = 4'd3; rd_idx_b = 4'd15;
        #1;
        check("R6", rd_data_a, 64'h0000_0000_0BAD_F00D);
        check("R6", rd_data_b, 64'h0000_0000_FFFF_FFFF);

        // Random writes checked against the model
        for (int n = 0; n < 400; n++) begin
            logic [63:0] r;
            r = next_rand();
            step(r[2:0] != 3'd0, r[6:3], r[8:7], next_rand(), r[12:9], 1'b0, 1'b0);
        end

        // R8: reset mid-run clears all entries
        @(negedge clk);
        wr_valid = 1'b0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < 16; i += 2) begin
            @(negedge clk);
            rd_idx_a = 4'(i); rd_idx_b = 4'(i + 1);
            #1;
            check("R8", rd_data_a, 64'h0);
            check("R8", rd_data_b, 64'h0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule